// File: doc/BRIEF.md
# Bus-Master IDE Channel Register File

This block holds the byte-wide control registers of a two-channel bus-master IDE controller and folds the interrupt requests of both drive channels into one level-sensitive PCI interrupt. A host reaches it through a plain register port: a channel select, a three-bit offset and a byte of write data. Reads are combinational and have no side effects. Writes take effect on the rising clock edge. Within a channel's eight-byte window the offsets are: command at 0, shared mode at 1, status at 2, channel timing at 3, and the descriptor table pointer as four little-endian bytes at 4 to 7.

The `EXTENDED` parameter picks the variant. The extended variant implements the shared mode register, which holds a pending bit and a block bit for each channel, and a timing byte per channel. The generic variant drops both: offsets 1 and 3 read as 0xFF and writes to them have no effect. The pending bits track the drive request levels in both variants. The PCI interrupt is raised whenever a pending channel is not blocked.

The DMA engine, descriptor walking and the ATA device registers are outside this block.

Top module: `busmaster_ide_regs`

## Requirements
- R1: After reset every register reads as zero (in the generic variant, offsets 1 and 3 read 0xFF) and `pci_irq_o` is low.
- R2: The command byte keeps only bit 0 (start) and bit 3 (read direction); the other bits read zero. A command write copies its bit 0 into the channel's status active bit (status bit 0).
- R3: A status write loads status bits 5 and 6 from the data, clears status bits 1 and 2 where the data has a one (write-one-to-clear), and leaves status bit 0 unchanged. Bits 3, 4 and 7 read zero.
- R4: Offsets 4 to 7 hold the descriptor pointer, least significant byte at offset 4, and each byte can be written on its own. Pointer bits 1:0 always read zero.
- R5: In the extended variant, a write to offset 1 through either channel changes only mode bits 4 and 5. Every other mode bit keeps its value.
- R6: Mode bit 2 is the channel 0 pending bit, bit 3 the channel 1 pending bit, bit 4 blocks channel 0 and bit 5 blocks channel 1. `pci_irq_o` equals (bit2 AND NOT bit4) OR (bit3 AND NOT bit5).
- R7: Each pending bit equals the channel's `drv_irq_i` level sampled at the previous clock edge.
- R8: A rising `drv_irq_i` sets bit 2 of that channel's status. The set wins over a write-one-to-clear in the same cycle, and the bit stays set after the request falls.
- R9: In the extended variant, offset 3 reads and writes a separate timing byte for each channel.
- R10: In the generic variant, offsets 1 and 3 read 0xFF and writes to them are ignored, so no channel can be blocked and `pci_irq_o` is the OR of the pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the addressed byte |
| chan_i | input | 1 | Channel select |
| offs_i | input | 3 | Byte offset within the channel window |
| wdata_i | input | 8 | Write data |
| drv_irq_i | input | 2 | Drive interrupt request level, one per channel |
| rdata_o | output | 8 | Read data for the addressed byte |
| pci_irq_o | output | 1 | Combined PCI interrupt level |

## Verification
The bound checker checks on every cycle that the pending bits follow the request levels one edge later and that the interrupt output matches those levels gated by the block bits. It also checks that the block bits move only on a mode write, that a rising request sets the status interrupt bit, and that a status write leaves the active bit alone. The bench's scenarios show the byte-level effects at the read port: masking in the command and pointer bytes, write-one-to-clear against write-load in status, per-channel separation of the timing bytes, the set-wins collision in status, and the 0xFF reads and ignored writes of the generic variant.

// File: rtl/bmide_pkg.sv
`timescale 1ns/1ps
package bmide_pkg;
  localparam int BYTE_W = 8;
  localparam int OFF_W  = 3;
  localparam int NUM_CH = 2;
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int ADR_W  = 32;
  localparam int ADR_BYTES = ADR_W / BYTE_W;

  localparam logic [OFF_W-1:0] OFF_CMD  = 3'd0;
  localparam logic [OFF_W-1:0] OFF_MODE = 3'd1;
  localparam logic [OFF_W-1:0] OFF_STS  = 3'd2;
  localparam logic [OFF_W-1:0] OFF_TIM  = 3'd3;
  localparam logic [OFF_W-1:0] OFF_ADR  = 3'd4;

  localparam int CMD_START = 0;
  localparam logic [BYTE_W-1:0] CMD_MASK = 8'h09;

  localparam int STS_ACT = 0;
  localparam int STS_INT = 2;
  localparam logic [BYTE_W-1:0] STS_RW_MASK  = 8'h60;
  localparam logic [BYTE_W-1:0] STS_ACT_MASK = 8'h01;
  localparam logic [BYTE_W-1:0] STS_W1C_MASK = 8'h06;

  localparam int MODE_PEND_LSB = 2;
  localparam int MODE_BLK_LSB  = 4;

  localparam logic [BYTE_W-1:0] ADR_LOW_MASK = 8'hFC;
  localparam logic [BYTE_W-1:0] ABSENT_BYTE  = 8'hFF;
endpackage

// File: rtl/bmide_chan_regs.sv
`timescale 1ns/1ps
module bmide_chan_regs
  import bmide_pkg::*;
#(
  parameter bit EXT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [OFF_W-1:0]  offs_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              irq_rise_i,
  output logic [BYTE_W-1:0] cmd_o,
  output logic [BYTE_W-1:0] sts_o,
  output logic [BYTE_W-1:0] tim_o,
  output logic [ADR_W-1:0]  adr_o
);
  logic [BYTE_W-1:0] cmd_q, sts_q, sts_d;

  always_comb begin
    sts_d = sts_q;
    if (wr_en_i && offs_i == OFF_STS)
      sts_d = (wdata_i & STS_RW_MASK) | (sts_q & STS_ACT_MASK)
            | (sts_q & ~wdata_i & STS_W1C_MASK);
    if (wr_en_i && offs_i == OFF_CMD)
      sts_d[STS_ACT] = wdata_i[CMD_START];
    // a new drive request wins over a same-cycle clear
    if (irq_rise_i)
      sts_d[STS_INT] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
      sts_q <= '0;
    end else begin
      sts_q <= sts_d;
      if (wr_en_i && offs_i == OFF_CMD) cmd_q <= wdata_i & CMD_MASK;
    end
  end

  assign cmd_o = cmd_q;
  assign sts_o = sts_q;

  for (genvar b = 0; b < ADR_BYTES; b++) begin : g_adr
    localparam logic [BYTE_W-1:0] KEEP = (b == 0) ? ADR_LOW_MASK : '1;
    localparam logic [OFF_W-1:0]  LANE = OFF_W'(int'(OFF_ADR) + b);
    logic [BYTE_W-1:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         lane_q <= '0;
      else if (wr_en_i && offs_i == LANE)  lane_q <= wdata_i & KEEP;
    end
    assign adr_o[b*BYTE_W +: BYTE_W] = lane_q;
  end

  if (EXT) begin : g_tim
    logic [BYTE_W-1:0] tim_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           tim_q <= '0;
      else if (wr_en_i && offs_i == OFF_TIM) tim_q <= wdata_i;
    end
    assign tim_o = tim_q;
  end else begin : g_no_tim
    assign tim_o = '0;
  end
endmodule

// File: rtl/bmide_mode_irq.sv
`timescale 1ns/1ps
module bmide_mode_irq
  import bmide_pkg::*;
#(
  parameter bit EXT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_wr_i,
  input  logic [NUM_CH-1:0] blk_wdata_i,
  input  logic [NUM_CH-1:0] drv_irq_i,
  output logic [NUM_CH-1:0] pend_o,
  output logic [NUM_CH-1:0] blk_o,
  output logic [NUM_CH-1:0] irq_rise_o,
  output logic [BYTE_W-1:0] mode_o,
  output logic              pci_irq_o
);
  logic [NUM_CH-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= drv_irq_i;
  end

  if (EXT) begin : g_blk
    logic [NUM_CH-1:0] blk_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        blk_q <= '0;
      else if (mode_wr_i) blk_q <= blk_wdata_i;
    end
    assign blk_o = blk_q;
  end else begin : g_no_blk
    logic unused_wr;
    assign unused_wr = mode_wr_i ^ (^blk_wdata_i);
    assign blk_o = '0;
  end

  assign irq_rise_o = drv_irq_i & ~pend_q;
  assign pend_o     = pend_q;

  always_comb begin
    mode_o = '0;
    mode_o[MODE_PEND_LSB +: NUM_CH] = pend_q;
    mode_o[MODE_BLK_LSB  +: NUM_CH] = blk_o;
  end

  assign pci_irq_o = |(pend_q & ~blk_o);
endmodule

// File: rtl/busmaster_ide_regs.sv
`timescale 1ns/1ps
module busmaster_ide_regs
  import bmide_pkg::*;
#(
  parameter bit EXTENDED = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic [OFF_W-1:0]  offs_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [NUM_CH-1:0] drv_irq_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              pci_irq_o
);
  logic [NUM_CH-1:0][BYTE_W-1:0] cmd_q, sts_q, tim_q;
  logic [NUM_CH-1:0][ADR_W-1:0]  adr_q;
  logic [NUM_CH-1:0]             pend_q, blk_q, irq_rise;
  logic [BYTE_W-1:0]             mode_byte;
  logic                          mode_wr;

  assign mode_wr = wr_en_i && (offs_i == OFF_MODE);

  bmide_mode_irq #(.EXT(EXTENDED)) u_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_wr_i   (mode_wr),
    .blk_wdata_i (wdata_i[MODE_BLK_LSB +: NUM_CH]),
    .drv_irq_i   (drv_irq_i),
    .pend_o      (pend_q),
    .blk_o       (blk_q),
    .irq_rise_o  (irq_rise),
    .mode_o      (mode_byte),
    .pci_irq_o   (pci_irq_o)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic ch_wr;
    assign ch_wr = wr_en_i && (chan_i == CH_W'(c));
    bmide_chan_regs #(.EXT(EXTENDED)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (ch_wr),
      .offs_i     (offs_i),
      .wdata_i    (wdata_i),
      .irq_rise_i (irq_rise[c]),
      .cmd_o      (cmd_q[c]),
      .sts_o      (sts_q[c]),
      .tim_o      (tim_q[c]),
      .adr_o      (adr_q[c])
    );
  end

  always_comb begin
    unique case (offs_i)
      OFF_CMD:  rdata_o = cmd_q[chan_i];
      OFF_MODE: rdata_o = EXTENDED ? mode_byte : ABSENT_BYTE;
      OFF_STS:  rdata_o = sts_q[chan_i];
      OFF_TIM:  rdata_o = EXTENDED ? tim_q[chan_i] : ABSENT_BYTE;
      default:  rdata_o = adr_q[chan_i][{offs_i[1:0], 3'b000} +: BYTE_W];
    endcase
  end
endmodule

// File: rtl/busmaster_ide_regs_chk.sv
`timescale 1ns/1ps
module busmaster_ide_regs_chk
  import bmide_pkg::*;
#(
  parameter bit EXT = 1'b1
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          wr_en_i,
  input logic [CH_W-1:0]               chan_i,
  input logic [OFF_W-1:0]              offs_i,
  input logic [NUM_CH-1:0]             drv_irq_i,
  input logic                          pci_irq_o,
  input logic [NUM_CH-1:0]             pend_q,
  input logic [NUM_CH-1:0]             blk_q,
  input logic [NUM_CH-1:0][BYTE_W-1:0] sts_q
);
  p_pend_follow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> pend_q == $past(drv_irq_i));

  p_irq_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> pci_irq_o == |($past(drv_irq_i) & ~blk_q));

  p_blk_only_on_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && offs_i == OFF_MODE) |=> $stable(blk_q));

  p_int_set_ch0_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drv_irq_i[0]) |=> sts_q[0][STS_INT]);

  p_int_set_ch1_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drv_irq_i[1]) |=> sts_q[1][STS_INT]);

  p_act_hold_ch0_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && chan_i == '0 && offs_i == OFF_STS) |=> $stable(sts_q[0][STS_ACT]));

  if (!EXT) begin : g_generic
    p_no_block_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> blk_q == '0);
  end
endmodule

bind busmaster_ide_regs busmaster_ide_regs_chk #(.EXT(EXTENDED)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .chan_i    (chan_i),
  .offs_i    (offs_i),
  .drv_irq_i (drv_irq_i),
  .pci_irq_o (pci_irq_o),
  .pend_q    (pend_q),
  .blk_q     (blk_q),
  .sts_q     (sts_q)
);

// File: tb/busmaster_ide_regs_bench.sv
`timescale 1ns/1ps
module busmaster_ide_regs_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic       chan = 1'b0;
  logic [2:0] offs = '0;
  logic [7:0] wdata = '0;
  logic [1:0] drv = '0;
  logic [7:0] rd_ext, rd_gen;
  logic       irq_ext, irq_gen;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  busmaster_ide_regs #(.EXTENDED(1'b1)) u_busmaster_ide_regs (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .chan_i(chan), .offs_i(offs),
    .wdata_i(wdata), .drv_irq_i(drv), .rdata_o(rd_ext), .pci_irq_o(irq_ext));

  busmaster_ide_regs #(.EXTENDED(1'b0)) u_gen (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .chan_i(chan), .offs_i(offs),
    .wdata_i(wdata), .drv_irq_i(drv), .rdata_o(rd_gen), .pci_irq_o(irq_gen));

  // {chan, offs, write data, expected read-back}, extended variant
  localparam int NV = 13;
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 3'd0, 8'hFF, 8'h09},
    {1'b0, 3'd2, 8'h00, 8'h01},
    {1'b0, 3'd2, 8'hFF, 8'h61},
    {1'b0, 3'd4, 8'hFF, 8'hFC},
    {1'b0, 3'd5, 8'hA5, 8'hA5},
    {1'b0, 3'd7, 8'h12, 8'h12},
    {1'b1, 3'd6, 8'h77, 8'h77},
    {1'b1, 3'd3, 8'h3C, 8'h3C},
    {1'b0, 3'd3, 8'hC3, 8'hC3},
    {1'b1, 3'd1, 8'hFF, 8'h30},
    {1'b0, 3'd1, 8'h00, 8'h00},
    {1'b1, 3'd0, 8'h08, 8'h08},
    {1'b0, 3'd0, 8'h00, 8'h00}
  };
  string vec_tag [NV] = '{"R2", "R3", "R3", "R4", "R4", "R4", "R4",
                          "R9", "R9", "R5", "R5", "R2", "R2"};

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic c, input logic [2:0] o, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; chan = c; offs = o; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic c, input logic [2:0] o);
    chan = c; offs = o;
    #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=%0d", checks, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int c = 0; c < 2; c++) begin
      for (int o = 0; o < 8; o++) begin
        rd(c[0], o[2:0]);
        chk("R1 ext", rd_ext, 8'h00);
        chk("R1 gen", rd_gen, (o == 1 || o == 3) ? 8'hFF : 8'h00);
      end
    end
    chk("R1 irq", {7'd0, irq_ext}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][19], VEC[i][18:16], VEC[i][15:8]);
      rd(VEC[i][19], VEC[i][18:16]);
      chk(vec_tag[i], rd_ext, VEC[i][7:0]);
    end

    rd(1'b0, 3'd2); chk("R2 active cleared by command", rd_ext, 8'h60);
    rd(1'b1, 3'd3); chk("R9 ch1 timing kept", rd_ext, 8'h3C);
    rd(1'b0, 3'd6); chk("R4 untouched pointer byte", rd_ext, 8'h00);
    rd(1'b0, 3'd3); chk("R10 gen timing ignored", rd_gen, 8'hFF);
    rd(1'b1, 3'd1); chk("R10 gen mode reads FF", rd_gen, 8'hFF);

    // channel 0 request
    @(negedge clk); drv = 2'b01;
    @(negedge clk);
    chk("R6 irq on pending", {7'd0, irq_ext}, 8'h01);
    rd(1'b0, 3'd1); chk("R7 pend0 bit2", rd_ext, 8'h04);
    rd(1'b0, 3'd2); chk("R8 status int set", rd_ext, 8'h64);

    wr(1'b0, 3'd1, 8'h10);
    rd(1'b0, 3'd1); chk("R5 block0 keeps pend", rd_ext, 8'h14);
    chk("R6 blocked irq low", {7'd0, irq_ext}, 8'h00);
    chk("R10 gen cannot block", {7'd0, irq_gen}, 8'h01);

    wr(1'b1, 3'd1, 8'hFF);
    rd(1'b1, 3'd1); chk("R5 only bits 5:4 change", rd_ext, 8'h34);

    wr(1'b0, 3'd1, 8'h00);
    chk("R6 unblocked irq high", {7'd0, irq_ext}, 8'h01);

    @(negedge clk); drv = 2'b00;
    @(negedge clk);
    rd(1'b0, 3'd1); chk("R7 pend cleared", rd_ext, 8'h00);
    chk("R6 irq low after drop", {7'd0, irq_ext}, 8'h00);
    rd(1'b0, 3'd2); chk("R8 int sticky", rd_ext, 8'h64);

    wr(1'b0, 3'd2, 8'h64);
    rd(1'b0, 3'd2); chk("R3 write-one-to-clear", rd_ext, 8'h60);

    // channel 1 request colliding with a clear of the same bit
    @(negedge clk);
    drv = 2'b10; we = 1'b1; chan = 1'b1; offs = 3'd2; wdata = 8'h04;
    @(negedge clk);
    we = 1'b0;
    rd(1'b1, 3'd2); chk("R8 set wins over clear", rd_ext, 8'h04);
    rd(1'b1, 3'd1); chk("R7 pend1 bit3", rd_ext, 8'h08);
    chk("R6 ch1 irq", {7'd0, irq_ext}, 8'h01);
    chk("R10 gen irq ch1", {7'd0, irq_gen}, 8'h01);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule